// File: doc/BRIEF.md
# AC-Link Frame Slot Formatter

This block is the slot timing and word alignment stage of a serial link to an audio codec that uses the AC-Link frame. Every clock cycle is one bit time. A frame lasts 256 bit times. It opens with a 16-bit tag slot, and twelve 20-bit data slots follow. The block counts bit positions inside the frame and reports the current slot on `slot_idx`. It drives the frame sync and marks the first and last bit of every slot with strobes.

On the transmit side, the block samples a buffer word in the first bit time of each slot and sends it out MSB first. On the receive side, it collects the incoming bits and hands over one aligned buffer word per slot. A 2-bit mode code picks how the data slots are aligned:

- In the wide mode, all 20 bits pass through unchanged.
- In the narrow mode, received data slots are cut to their upper 16 bits and transmitted data slots carry four trailing zeros, so buffer words always hold 16-bit samples right-justified.
- The tag slot is always 16 bits and is never reformatted.

Top module: `acl_slot_formatter`

## Requirements
- R1: A frame is 256 bit times: slot 0 lasts 16 bit times, slots 1 to 12 last 20 each. `slot_idx` gives the current slot. `slot_end` is high in the final bit time of each slot, and slot 12 is followed by slot 0.
- R2: `frame_sync` is high for exactly the 16 bit times of slot 0 and low for the other 240 bit times.
- R3: Mode codes 2'b00 and 2'b01 are idle. While idle, `frame_sync`, `slot_idx`, `slot_end`, `tx_load` and `ser_tx` are all 0. Counting restarts, so the first cycle with mode 2'b1x is bit 0 of slot 0.
- R4: `tx_load` is high in the first bit time of every slot, and `tx_word` is sampled in that cycle. Bits leave on `ser_tx` MSB first, and the first bit appears in the same cycle.
- R5: Slot 0 carries 16 bits in both modes. It transmits `tx_word[15:0]` and receives into `rx_word[15:0]` with `rx_word[19:16]` = 0.
- R6: In mode 2'b11, a data slot transmits `tx_word[19:0]`, and the 20 received bits are stored in `rx_word[19:0]`, first-received bit in bit 19.
- R7: In mode 2'b10, a data slot transmits `tx_word[15:0]` followed by four 0 bits. `tx_word[19:16]` has no effect.
- R8: In mode 2'b10, a received data slot keeps its first 16 bits in `rx_word[15:0]` and drops its last 4 bits. `rx_word[19:16]` = 0.
- R9: `rx_valid` pulses for one cycle, in the cycle after each `slot_end`. `rx_slot` then holds the index of the completed slot.
- R10: A synchronous active-high `rst` forces every output to 0 while asserted and restarts the frame at slot 0 bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Frame-mode code: 2'b10 narrow, 2'b11 wide, others idle |
| tx_word | input | 20 | Transmit buffer word for the current slot, sampled when tx_load is high |
| ser_rx | input | 1 | Received serial bit |
| frame_sync | output | 1 | High during slot 0 |
| slot_idx | output | 4 | Current slot, 0 to 12 |
| slot_end | output | 1 | Final bit time of the current slot |
| tx_load | output | 1 | First bit time of the current slot |
| ser_tx | output | 1 | Transmitted serial bit |
| rx_valid | output | 1 | rx_word and rx_slot hold a completed slot |
| rx_slot | output | 4 | Index of the completed receive slot |
| rx_word | output | 20 | Aligned received buffer word |

## Verification
The assertions check the following on every cycle:
- the frame and tag lengths, against an independent bit-position counter
- the slot sequence and the one-cycle drop of the sync after slot 0
- quiet outputs in idle
- the zero padding of narrow transmit slots
- the cleared upper bits of tag and narrow receive words
- the link between a receive pulse and the preceding slot end

Only the bench scenarios can show that the transmitted and received bit values match the buffer words under each mode. The same holds for a restart after idle or a mid-frame reset landing exactly on slot 0 bit 0, and for `tx_word[19:16]` having no effect in narrow mode.

// File: rtl/acl_pkg.sv
package acl_pkg;

    localparam int TAG_BITS    = 16;
    localparam int DATA_BITS   = 20;
    localparam int DATA_SLOTS  = 12;
    localparam int NARROW_BITS = 16;
    localparam int WORD_W      = DATA_BITS;
    localparam int PAD_W       = WORD_W - NARROW_BITS;
    localparam int FRAME_BITS  = TAG_BITS + DATA_SLOTS * DATA_BITS;
    localparam int SLOT_W      = $clog2(DATA_SLOTS + 1);
    localparam int CNT_W       = $clog2(DATA_BITS);
    localparam int POS_W       = $clog2(FRAME_BITS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [1:0] {
        MODE_OFF_A  = 2'b00,
        MODE_OFF_B  = 2'b01,
        MODE_NARROW = 2'b10,
        MODE_WIDE   = 2'b11
    } fmode_e;

    typedef struct packed {
        slot_t            slot;
        logic [CNT_W-1:0] bit_idx;
        logic             first;
        logic             last;
        logic             tag;
    } slot_pos_t;

    // Serial-order word: bit WORD_W-1 leaves first.
    function automatic word_t tx_align(input word_t w, input logic short_fmt);
        if (short_fmt)
            return {w[NARROW_BITS-1:0], {PAD_W{1'b0}}};
        return w;
    endfunction

    // full holds the latest WORD_W received bits, newest in bit 0.
    function automatic word_t rx_extract(input word_t full, input logic tag,
                                         input logic narrow);
        if (tag)
            return {{(WORD_W-TAG_BITS){1'b0}}, full[TAG_BITS-1:0]};
        if (narrow)
            return {{PAD_W{1'b0}}, full[WORD_W-1:PAD_W]};
        return full;
    endfunction

endpackage

// File: rtl/acl_frame_counter.sv
module acl_frame_counter
    import acl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    output slot_pos_t pos
);
    slot_t            slot_q;
    logic [CNT_W-1:0] bit_q;
    logic [CNT_W-1:0] last_idx;
    logic             is_tag;
    logic             at_last;

    assign is_tag   = (slot_q == '0);
    assign last_idx = is_tag ? CNT_W'(TAG_BITS - 1) : CNT_W'(DATA_BITS - 1);
    assign at_last  = (bit_q == last_idx);

    always_ff @(posedge clk) begin
        if (!active) begin
            slot_q <= '0;
            bit_q  <= '0;
        end else if (at_last) begin
            bit_q  <= '0;
            slot_q <= (slot_q == SLOT_W'(DATA_SLOTS)) ? '0 : slot_q + 1'b1;
        end else begin
            bit_q  <= bit_q + 1'b1;
        end
    end

    always_comb begin
        pos.slot    = slot_q;
        pos.bit_idx = bit_q;
        pos.first   = (bit_q == '0);
        pos.last    = at_last;
        pos.tag     = is_tag;
    end

    // Independent frame position counter for checking only.
    logic [POS_W-1:0] chk_pos;
    always_ff @(posedge clk) begin
        if (!active) chk_pos <= '0;
        else         chk_pos <= chk_pos + 1'b1;
    end

    assert_frame_len_R1: assert property (@(posedge clk) disable iff (rst)
        active && at_last && slot_q == SLOT_W'(DATA_SLOTS) |-> chk_pos == POS_W'(FRAME_BITS - 1));

    assert_tag_len_R1: assert property (@(posedge clk) disable iff (rst)
        active && at_last && is_tag |-> chk_pos == POS_W'(TAG_BITS - 1));

    assert_slot_seq_R1: assert property (@(posedge clk) disable iff (rst)
        active && at_last && slot_q != SLOT_W'(DATA_SLOTS) |=> !active || slot_q == $past(slot_q) + 1'b1);

endmodule

// File: rtl/acl_tx_shifter.sv
module acl_tx_shifter
    import acl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             first,
    input  logic             tag,
    input  logic [CNT_W-1:0] bit_idx,
    input  logic             narrow,
    input  word_t            tx_word,
    output logic             ser_tx
);
    word_t sh_q;
    word_t aligned;
    logic  narrow_q;

    assign aligned = tx_align(tx_word, tag || narrow);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            narrow_q <= 1'b0;
        end else if (active && first) begin
            sh_q     <= aligned << 1;
            narrow_q <= narrow && !tag;
        end else begin
            sh_q     <= sh_q << 1;
        end
    end

    assign ser_tx = !active ? 1'b0 : (first ? aligned[WORD_W-1] : sh_q[WORD_W-1]);

    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (rst)
        active && !first && narrow_q && !tag && bit_idx >= CNT_W'(NARROW_BITS) |-> !ser_tx);

endmodule

// File: rtl/acl_rx_assembler.sv
module acl_rx_assembler
    import acl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  last,
    input  logic  tag,
    input  slot_t slot,
    input  logic  narrow,
    input  logic  ser_rx,
    output logic  rx_valid,
    output slot_t rx_slot,
    output word_t rx_word
);
    word_t sh_q;
    word_t full;

    assign full = {sh_q[WORD_W-2:0], ser_rx};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            rx_valid <= 1'b0;
            rx_slot  <= '0;
            rx_word  <= '0;
        end else begin
            sh_q     <= full;
            rx_valid <= active && last;
            if (active && last) begin
                rx_slot <= slot;
                rx_word <= rx_extract(full, tag, narrow);
            end
        end
    end

    assert_rx_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(active && last));

    assert_rx_tag_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_slot == '0 |-> rx_word[WORD_W-1:TAG_BITS] == '0);

    assert_rx_narrow_R8: assert property (@(posedge clk) disable iff (rst)
        rx_valid && $past(narrow && !tag) |-> rx_word[WORD_W-1:NARROW_BITS] == '0);

endmodule

// File: rtl/acl_slot_formatter.sv
module acl_slot_formatter
    import acl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode,
    input  logic [19:0] tx_word,
    input  logic        ser_rx,
    output logic        frame_sync,
    output logic [3:0]  slot_idx,
    output logic        slot_end,
    output logic        tx_load,
    output logic        ser_tx,
    output logic        rx_valid,
    output logic [3:0]  rx_slot,
    output logic [19:0] rx_word
);
    fmode_e    mode_e;
    logic      active;
    logic      narrow;
    slot_pos_t pos;

    assign mode_e = fmode_e'(mode);
    assign active = !rst && (mode_e == MODE_NARROW || mode_e == MODE_WIDE);
    assign narrow = (mode_e == MODE_NARROW);

    acl_frame_counter u_counter (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .pos    (pos)
    );

    acl_tx_shifter u_tx (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .first   (pos.first),
        .tag     (pos.tag),
        .bit_idx (pos.bit_idx),
        .narrow  (narrow),
        .tx_word (tx_word),
        .ser_tx  (ser_tx)
    );

    acl_rx_assembler u_rx (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .last     (pos.last),
        .tag      (pos.tag),
        .slot     (pos.slot),
        .narrow   (narrow),
        .ser_rx   (ser_rx),
        .rx_valid (rx_valid),
        .rx_slot  (rx_slot),
        .rx_word  (rx_word)
    );

    assign frame_sync = active && pos.tag;
    assign slot_idx   = active ? pos.slot : '0;
    assign slot_end   = active && pos.last;
    assign tx_load    = active && pos.first;

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !mode[1] |-> !frame_sync && !ser_tx && !slot_end && !tx_load && slot_idx == '0);

    assert_sync_drop_R2: assert property (@(posedge clk) disable iff (rst)
        frame_sync && slot_end |=> !frame_sync);

    assert_sync_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_sync) |-> tx_load);

endmodule

// File: tb/acl_slot_formatter_bench.sv
module acl_slot_formatter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic [19:0] tx_word = '0;
    logic        ser_rx = 1'b0;
    logic        frame_sync, slot_end, tx_load, ser_tx, rx_valid;
    logic [3:0]  slot_idx, rx_slot;
    logic [19:0] rx_word;

    int checks = 0;
    int errors = 0;
    int seed_v = 0;

    // model state
    int          mpos = 0;
    logic [19:0] etx = '0;
    logic [19:0] erx = '0;
    logic        pv = 1'b0;
    logic [3:0]  ps = '0;
    logic [19:0] pw = '0;

    always #5 clk = ~clk;

    acl_slot_formatter u_acl_slot_formatter (
        .clk(clk), .rst(rst), .mode(mode), .tx_word(tx_word), .ser_rx(ser_rx),
        .frame_sync(frame_sync), .slot_idx(slot_idx), .slot_end(slot_end),
        .tx_load(tx_load), .ser_tx(ser_tx), .rx_valid(rx_valid),
        .rx_slot(rx_slot), .rx_word(rx_word)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_tx(input logic [19:0] w, input bit tag, input bit nar);
        logic [19:0] r;
        r = w;
        if (tag || nar) r = {w[15:0], 4'b0000};
        return r;
    endfunction

    function automatic logic [19:0] exp_rx(input logic [19:0] bits, input bit tag, input bit nar);
        if (tag) return {4'b0000, bits[15:0]};
        if (nar) return {4'b0000, bits[19:4]};
        return bits;
    endfunction

    // pat: 0 random, 1 all ones, 2 ones only in bits 19:16
    task automatic step(input logic [1:0] m, input logic r, input int pat);
        bit   act, tag, nar, last;
        int   slot, bis, len;
        string txreq;
        @(negedge clk);
        mode = m;
        rst  = r;
        case (pat)
            1: begin tx_word = 20'hFFFFF; ser_rx = 1'b1; end
            2: begin tx_word = 20'hF0000; ser_rx = $urandom(); end
            default: begin tx_word = 20'($urandom()); ser_rx = 1'($urandom()); end
        endcase
        #1;
        act  = m[1] && !r;
        nar  = (m == 2'b10);
        slot = (mpos < 16) ? 0 : 1 + (mpos - 16) / 20;
        bis  = (mpos < 16) ? mpos : (mpos - 16) % 20;
        len  = (slot == 0) ? 16 : 20;
        tag  = (slot == 0);
        last = (bis == len - 1);

        chk("R9", "rx_valid", 32'(rx_valid), 32'(pv));
        if (pv) begin
            chk("R9", "rx_slot", 32'(rx_slot), 32'(ps));
            chk((ps == 0) ? "R5" : (nar ? "R8" : "R6"), "rx_word", 32'(rx_word), 32'(pw));
        end
        if (act) begin
            chk("R2", "frame_sync", 32'(frame_sync), 32'(tag));
            chk("R1", "slot_idx", 32'(slot_idx), 32'(slot));
            chk("R1", "slot_end", 32'(slot_end), 32'(last));
            chk("R4", "tx_load", 32'(tx_load), 32'(bis == 0));
            if (bis == 0) etx = exp_tx(tx_word, tag, nar);
            txreq = tag ? "R5" : (nar ? "R7" : "R6");
            chk(txreq, "ser_tx", 32'(ser_tx), 32'(etx[19-bis]));
        end else begin
            txreq = r ? "R10" : "R3";
            chk(txreq, "frame_sync", 32'(frame_sync), 0);
            chk(txreq, "slot_idx", 32'(slot_idx), 0);
            chk(txreq, "slot_end", 32'(slot_end), 0);
            chk(txreq, "tx_load", 32'(tx_load), 0);
            chk(txreq, "ser_tx", 32'(ser_tx), 0);
        end
        // model update for the coming edge
        erx = {erx[18:0], ser_rx};
        if (act && last) begin
            pv = 1'b1; ps = 4'(slot); pw = exp_rx(erx, tag, nar);
        end else pv = 1'b0;
        if (r) pv = 1'b0;
        mpos = act ? (mpos + 1) % 256 : 0;
    endtask

    task automatic run(input logic [1:0] m, input int n, input int pat);
        for (int i = 0; i < n; i++) step(m, 1'b0, pat);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        seed_v = $urandom(32'd1234);
        // R10: reset state with an active mode requested
        for (int i = 0; i < 3; i++) step(2'b11, 1'b1, 0);
        // R6: wide mode, two full frames
        run(2'b11, 520, 0);
        // R3: idle codes
        run(2'b01, 7, 0);
        run(2'b00, 5, 0);
        // R7 / R8: narrow mode, all ones then upper nibble only
        run(2'b10, 256, 1);
        run(2'b10, 256, 2);
        run(2'b10, 300, 0);
        // R10: mid-frame reset, then restart at slot 0
        run(2'b11, 137, 0);
        step(2'b11, 1'b1, 0);
        run(2'b11, 300, 0);
        // R3: drop to idle mid-frame and restart
        run(2'b00, 1, 0);
        run(2'b11, 40, 1);
        // random segments
        for (int k = 0; k < 12; k++) begin
            logic [1:0] mm;
            mm = 2'($urandom());
            run(mm, 1 + int'($urandom() % 600), 0);
            run(2'b00, 1, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule